// File: doc/BRIEF.md
# Interrupt translation lookup engine

This block turns a device ID and event ID pair into a physical interrupt number and the collection that interrupt belongs to. A request arrives either as a queued command (INT, CLEAR or DISCARD), whose two doublewords carry the device ID and the event ID, or as a direct write to the translation register. In the register case the requester ID of the write stands in for the device ID and the written data is the event ID.

Once a request is accepted, the engine reads three entries, one after another, through a single request/response lookup port. It reads the device entry, then the translation entry at an address built from the device entry, then the collection entry. Every response is validated before the next read goes out. The first failing check ends the request, and nothing further is read or written. A successful INT, CLEAR or register request presents the interrupt and collection IDs with a one-cycle strobe and a kind tag. A successful DISCARD instead emits a one-cycle write of an all-zero translation entry at the address it just read.

Top module: `itl_lookup_engine`

## Requirements
- R1: After reset `req_ready` is 1 and `hit_valid`, `itt_wr_valid` and `lk_req_valid` are 0. A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while no request is in flight. Request kinds are 0 = register write, 1 = CLEAR, 2 = DISCARD, 3 = INT.
- R2: For kind 0 the device ID is `wr_reqid` and the event ID is `wr_data`. When `wr_half` is 1, only `wr_data[15:0]` is used and the upper event bits are zero.
- R3: A kind 0 request taken while `ctl_enable` is 0 issues no lookup and produces no output. Command kinds are processed whatever the value of `ctl_enable`.
- R4: For kinds 1 to 3 the device ID is `cmd_dw0[32 +: DEVID_W]` and the event ID is `cmd_dw1[31:0]`. All other command bits have no effect.
- R5: A request whose device ID is greater than `DEV_LIMIT` is dropped before any lookup. A device ID equal to `DEV_LIMIT` is looked up.
- R6: Lookups go out strictly in the order device (table code 0, address = device ID), translation (code 1, byte address = device entry bits [6 +: ADDR_W-8] shifted left by 8, plus event ID times 8), collection (code 2, address = collection ID). Each request holds its code and address stable until `lk_req_ready` is 1, and each waits for `lk_rsp_valid`.
- R7: In a device entry, bit 0 is valid and bits [5:1] hold a size field. If the entry is invalid, or the event ID is greater than 2^(size+1), the request ends with no translation lookup. An event ID equal to 2^(size+1) passes.
- R8: In a translation entry, bit 0 is valid, bit 1 marks physical type, bits [8 +: INTID_W] hold the interrupt ID and bits [32 +: ICID_W] hold the collection ID. If the entry is not valid or not physical, the request ends with no collection lookup.
- R9: A collection entry is valid when its bit 0 is 1. If it is invalid, the request ends with no output.
- R10: When kind 0, 1 or 3 succeeds, `hit_valid` pulses for exactly one cycle, starting the cycle after the collection response. In that cycle `hit_kind` equals the request kind and `hit_intid` and `hit_icid` come from the translation entry.
- R11: When DISCARD succeeds, `itt_wr_valid` pulses for one cycle with `itt_wr_addr` equal to the translation address and `itt_wr_data` all zero. `hit_valid` stays 0.
- R12: A request that fails at any stage produces neither `hit_valid` nor `itt_wr_valid`, and `req_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Translation enable; gates register-write requests |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_kind | input | 2 | Request kind code |
| cmd_dw0 | input | 64 | First command doubleword (device ID field) |
| cmd_dw1 | input | 64 | Second command doubleword (event ID field) |
| wr_data | input | 32 | Data of a translation register write |
| wr_half | input | 1 | Register write is 16 bits wide |
| wr_reqid | input | DEVID_W | Requester ID of the register write |
| lk_req_valid | output | 1 | Lookup request valid |
| lk_req_ready | input | 1 | Lookup request taken |
| lk_req_tbl | output | 2 | Table code of the lookup |
| lk_req_addr | output | ADDR_W | Index or byte address of the lookup |
| lk_rsp_valid | input | 1 | Lookup response valid |
| lk_rsp_data | input | 64 | Lookup response entry |
| hit_valid | output | 1 | One-cycle success strobe |
| hit_kind | output | 2 | Kind of the successful request |
| hit_intid | output | INTID_W | Resolved interrupt ID |
| hit_icid | output | ICID_W | Resolved collection ID |
| itt_wr_valid | output | 1 | One-cycle translation entry write strobe |
| itt_wr_addr | output | ADDR_W | Byte address of the entry to clear |
| itt_wr_data | output | 64 | Entry data written (all zero) |

## Verification
On every cycle the assertions check several properties: the engine is never ready while a lookup is pending, lookups follow the device, translation, collection order, a lookup request holds steady while stalled, a disabled register write leaves the engine idle, and the hit and write strobes last one cycle, never coincide and always follow a response. Only the bench scenarios can show that the values are right. That covers the field positions used to extract IDs, the translation address arithmetic, the event range boundary at exactly 2^(size+1), the device limit edge, and the fact that a DISCARD really removes a mapping so that a later INT on the same event fails.

// File: rtl/itl_pkg.sv
package itl_pkg;

   localparam int EVENT_W = 32;
   localparam int RSP_W   = 64;

   // device entry layout
   localparam int DEV_SIZE_LO = 1;
   localparam int DEV_SIZE_W  = 5;
   localparam int DEV_BASE_LO = 6;
   // translation entry layout
   localparam int XL_PHYS_BIT = 1;
   localparam int XL_INTID_LO = 8;
   localparam int XL_ICID_LO  = 32;
   // translation table geometry
   localparam int XL_ALIGN_SH = 8;
   localparam int XL_ENTRY_SH = 3;
   localparam int RANGE_W     = (1 << DEV_SIZE_W) + 1;

   typedef enum logic [1:0] {
      KIND_REGWR   = 2'd0,
      KIND_CLEAR   = 2'd1,
      KIND_DISCARD = 2'd2,
      KIND_INT     = 2'd3
   } itl_kind_e;

   typedef enum logic [1:0] {
      TBL_DEV  = 2'd0,
      TBL_XL   = 2'd1,
      TBL_COLL = 2'd2
   } itl_tbl_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV_REQ,
      ST_DEV_RSP,
      ST_XL_REQ,
      ST_XL_RSP,
      ST_CO_REQ,
      ST_CO_RSP
   } itl_state_e;

endpackage

// File: rtl/itl_req_decode.sv
module itl_req_decode
   import itl_pkg::*;
#(
   parameter int          DEVID_W   = 20,
   parameter int unsigned DEV_LIMIT = 4095
) (
   input  logic [1:0]         kind,
   input  logic [63:0]        cmd_dw0,
   input  logic [63:0]        cmd_dw1,
   input  logic [31:0]        wr_data,
   input  logic               wr_half,
   input  logic [DEVID_W-1:0] wr_reqid,
   input  logic               ctl_enable,
   output logic [DEVID_W-1:0] devid,
   output logic [EVENT_W-1:0] eventid,
   output logic               drop
);
   logic is_reg;
   logic [EVENT_W-1:0] reg_event;

   assign is_reg    = (kind == KIND_REGWR);
   assign reg_event = wr_half ? {16'h0000, wr_data[15:0]} : wr_data;
   assign devid     = is_reg ? wr_reqid : cmd_dw0[32 +: DEVID_W];
   assign eventid   = is_reg ? reg_event : cmd_dw1[31:0];
   assign drop      = (is_reg && !ctl_enable) || (devid > DEVID_W'(DEV_LIMIT));

   logic unused_cmd;
   generate
      if (DEVID_W < 32) begin : g_part_dw0
         assign unused_cmd = ^{cmd_dw0[31:0], cmd_dw0[63:32+DEVID_W], cmd_dw1[63:32]};
      end else begin : g_full_dw0
         assign unused_cmd = ^{cmd_dw0[31:0], cmd_dw1[63:32]};
      end
   endgenerate
endmodule

// File: rtl/itl_entry_decode.sv
module itl_entry_decode
   import itl_pkg::*;
#(
   parameter int ADDR_W  = 48,
   parameter int INTID_W = 24,
   parameter int ICID_W  = 16
) (
   input  logic [RSP_W-1:0]   rsp,
   input  logic [EVENT_W-1:0] eventid,
   output logic               dev_ok,
   output logic [ADDR_W-1:0]  xl_addr,
   output logic               xl_ok,
   output logic [INTID_W-1:0] intid,
   output logic [ICID_W-1:0]  icid,
   output logic               col_ok
);
   localparam int BASE_W = ADDR_W - XL_ALIGN_SH;
   localparam int OFF_W  = EVENT_W + XL_ENTRY_SH;
   localparam int TOP_A  = DEV_BASE_LO + BASE_W;
   localparam int TOP_B  = XL_ICID_LO + ICID_W;
   localparam int TOP_C  = XL_INTID_LO + INTID_W;
   localparam int TOP_AB = (TOP_A > TOP_B) ? TOP_A : TOP_B;
   localparam int HI_USED = (TOP_AB > TOP_C) ? TOP_AB : TOP_C;

   logic [DEV_SIZE_W-1:0] size;
   logic [DEV_SIZE_W:0]   shamt;
   logic [RANGE_W-1:0]    limit;
   logic [BASE_W-1:0]     base;
   logic [OFF_W-1:0]      offset;

   // device stage: valid bit and event range
   assign size   = rsp[DEV_SIZE_LO +: DEV_SIZE_W];
   assign shamt  = {1'b0, size} + 1'b1;
   assign limit  = RANGE_W'(1) << shamt;
   assign dev_ok = rsp[0] && (RANGE_W'(eventid) <= limit);

   // translation address from the device entry base and the event
   assign base    = rsp[DEV_BASE_LO +: BASE_W];
   assign offset  = {eventid, {XL_ENTRY_SH{1'b0}}};
   assign xl_addr = {base, {XL_ALIGN_SH{1'b0}}} + ADDR_W'(offset);

   // translation stage fields
   assign xl_ok = rsp[0] && rsp[XL_PHYS_BIT];
   assign intid = rsp[XL_INTID_LO +: INTID_W];
   assign icid  = rsp[XL_ICID_LO +: ICID_W];

   // collection stage
   assign col_ok = rsp[0];

   generate
      if (HI_USED < RSP_W) begin : g_spare
         logic unused_rsp_hi;
         assign unused_rsp_hi = ^rsp[RSP_W-1:HI_USED];
      end
   endgenerate
endmodule

// File: rtl/itl_walk_fsm.sv
module itl_walk_fsm
   import itl_pkg::*;
#(
   parameter int DEVID_W = 20,
   parameter int ADDR_W  = 48,
   parameter int INTID_W = 24,
   parameter int ICID_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [1:0]         kind_in,
   input  logic [DEVID_W-1:0] devid_in,
   input  logic [EVENT_W-1:0] eventid_in,
   input  logic               drop_in,
   output logic [EVENT_W-1:0] eventid_q,
   output logic               lk_req_valid,
   input  logic               lk_req_ready,
   output logic [1:0]         lk_req_tbl,
   output logic [ADDR_W-1:0]  lk_req_addr,
   input  logic               lk_rsp_valid,
   input  logic               dev_ok,
   input  logic [ADDR_W-1:0]  xl_addr,
   input  logic               xl_ok,
   input  logic [INTID_W-1:0] intid,
   input  logic [ICID_W-1:0]  icid,
   input  logic               col_ok,
   output logic               hit_valid,
   output logic [1:0]         hit_kind,
   output logic [INTID_W-1:0] hit_intid,
   output logic [ICID_W-1:0]  hit_icid,
   output logic               wr_valid,
   output logic [ADDR_W-1:0]  wr_addr
);
   itl_state_e state;
   logic [1:0]         kind_q;
   logic [DEVID_W-1:0] devid_q;
   logic [ADDR_W-1:0]  xl_addr_q;
   logic [INTID_W-1:0] intid_q;
   logic [ICID_W-1:0]  icid_q;

   assign req_ready    = (state == ST_IDLE);
   assign lk_req_valid = (state == ST_DEV_REQ) || (state == ST_XL_REQ) || (state == ST_CO_REQ);

   always_comb begin
      lk_req_tbl  = TBL_DEV;
      lk_req_addr = ADDR_W'(devid_q);
      case (state)
         ST_XL_REQ: begin
            lk_req_tbl  = TBL_XL;
            lk_req_addr = xl_addr_q;
         end
         ST_CO_REQ: begin
            lk_req_tbl  = TBL_COLL;
            lk_req_addr = ADDR_W'(icid_q);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind_q    <= '0;
         devid_q   <= '0;
         eventid_q <= '0;
         xl_addr_q <= '0;
         intid_q   <= '0;
         icid_q    <= '0;
         hit_valid <= 1'b0;
         hit_kind  <= '0;
         hit_intid <= '0;
         hit_icid  <= '0;
         wr_valid  <= 1'b0;
         wr_addr   <= '0;
      end else begin
         hit_valid <= 1'b0;
         wr_valid  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid && !drop_in) begin
                  kind_q    <= kind_in;
                  devid_q   <= devid_in;
                  eventid_q <= eventid_in;
                  state     <= ST_DEV_REQ;
               end
            end
            ST_DEV_REQ: if (lk_req_ready) state <= ST_DEV_RSP;
            ST_DEV_RSP: begin
               if (lk_rsp_valid) begin
                  if (dev_ok) begin
                     xl_addr_q <= xl_addr;
                     state     <= ST_XL_REQ;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_XL_REQ: if (lk_req_ready) state <= ST_XL_RSP;
            ST_XL_RSP: begin
               if (lk_rsp_valid) begin
                  if (xl_ok) begin
                     intid_q <= intid;
                     icid_q  <= icid;
                     state   <= ST_CO_REQ;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_CO_REQ: if (lk_req_ready) state <= ST_CO_RSP;
            ST_CO_RSP: begin
               if (lk_rsp_valid) begin
                  state <= ST_IDLE;
                  if (col_ok) begin
                     if (kind_q == KIND_DISCARD) begin
                        wr_valid <= 1'b1;
                        wr_addr  <= xl_addr_q;
                     end else begin
                        hit_valid <= 1'b1;
                        hit_kind  <= kind_q;
                        hit_intid <= intid_q;
                        hit_icid  <= icid_q;
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/itl_lookup_engine.sv
module itl_lookup_engine
   import itl_pkg::*;
#(
   parameter int          DEVID_W   = 20,
   parameter int          ADDR_W    = 48,
   parameter int          INTID_W   = 24,
   parameter int          ICID_W    = 16,
   parameter int unsigned DEV_LIMIT = 4095
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_enable,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [1:0]         req_kind,
   input  logic [63:0]        cmd_dw0,
   input  logic [63:0]        cmd_dw1,
   input  logic [31:0]        wr_data,
   input  logic               wr_half,
   input  logic [DEVID_W-1:0] wr_reqid,
   output logic               lk_req_valid,
   input  logic               lk_req_ready,
   output logic [1:0]         lk_req_tbl,
   output logic [ADDR_W-1:0]  lk_req_addr,
   input  logic               lk_rsp_valid,
   input  logic [63:0]        lk_rsp_data,
   output logic               hit_valid,
   output logic [1:0]         hit_kind,
   output logic [INTID_W-1:0] hit_intid,
   output logic [ICID_W-1:0]  hit_icid,
   output logic               itt_wr_valid,
   output logic [ADDR_W-1:0]  itt_wr_addr,
   output logic [63:0]        itt_wr_data
);
   generate
      if (DEVID_W < 1 || DEVID_W > 32) begin : g_bad_devid_w
         $error("DEVID_W must lie in 1..32");
      end
      if (ADDR_W < EVENT_W + XL_ENTRY_SH + 1 || ADDR_W > RSP_W - DEV_BASE_LO + XL_ALIGN_SH) begin : g_bad_addr_w
         $error("ADDR_W outside the range the entry layout supports");
      end
      if (INTID_W < 1 || INTID_W > XL_ICID_LO - XL_INTID_LO) begin : g_bad_intid_w
         $error("INTID_W overlaps the collection field");
      end
      if (ICID_W < 1 || ICID_W > RSP_W - XL_ICID_LO) begin : g_bad_icid_w
         $error("ICID_W exceeds the entry");
      end
      if (ICID_W > ADDR_W || DEVID_W > ADDR_W) begin : g_bad_index_w
         $error("lookup indexes must fit the lookup address");
      end
      if (DEVID_W < 32 && DEV_LIMIT >= (64'd1 << DEVID_W)) begin : g_bad_limit
         $error("DEV_LIMIT does not fit DEVID_W");
      end
   endgenerate

   logic [DEVID_W-1:0] dec_devid;
   logic [EVENT_W-1:0] dec_event;
   logic               dec_drop;
   logic [EVENT_W-1:0] event_q;
   logic               dev_ok, xl_ok, col_ok;
   logic [ADDR_W-1:0]  xl_addr;
   logic [INTID_W-1:0] ent_intid;
   logic [ICID_W-1:0]  ent_icid;

   itl_req_decode #(.DEVID_W(DEVID_W), .DEV_LIMIT(DEV_LIMIT)) u_decode (
      .kind       (req_kind),
      .cmd_dw0    (cmd_dw0),
      .cmd_dw1    (cmd_dw1),
      .wr_data    (wr_data),
      .wr_half    (wr_half),
      .wr_reqid   (wr_reqid),
      .ctl_enable (ctl_enable),
      .devid      (dec_devid),
      .eventid    (dec_event),
      .drop       (dec_drop)
   );

   itl_entry_decode #(.ADDR_W(ADDR_W), .INTID_W(INTID_W), .ICID_W(ICID_W)) u_entry (
      .rsp     (lk_rsp_data),
      .eventid (event_q),
      .dev_ok  (dev_ok),
      .xl_addr (xl_addr),
      .xl_ok   (xl_ok),
      .intid   (ent_intid),
      .icid    (ent_icid),
      .col_ok  (col_ok)
   );

   itl_walk_fsm #(.DEVID_W(DEVID_W), .ADDR_W(ADDR_W), .INTID_W(INTID_W), .ICID_W(ICID_W)) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .kind_in      (req_kind),
      .devid_in     (dec_devid),
      .eventid_in   (dec_event),
      .drop_in      (dec_drop),
      .eventid_q    (event_q),
      .lk_req_valid (lk_req_valid),
      .lk_req_ready (lk_req_ready),
      .lk_req_tbl   (lk_req_tbl),
      .lk_req_addr  (lk_req_addr),
      .lk_rsp_valid (lk_rsp_valid),
      .dev_ok       (dev_ok),
      .xl_addr      (xl_addr),
      .xl_ok        (xl_ok),
      .intid        (ent_intid),
      .icid         (ent_icid),
      .col_ok       (col_ok),
      .hit_valid    (hit_valid),
      .hit_kind     (hit_kind),
      .hit_intid    (hit_intid),
      .hit_icid     (hit_icid),
      .wr_valid     (itt_wr_valid),
      .wr_addr      (itt_wr_addr)
   );

   assign itt_wr_data = '0;
endmodule

// File: rtl/itl_lookup_engine_chk.sv
module itl_lookup_engine_chk #(
   parameter int ADDR_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_enable,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_kind,
   input logic              lk_req_valid,
   input logic              lk_req_ready,
   input logic [1:0]        lk_req_tbl,
   input logic [ADDR_W-1:0] lk_req_addr,
   input logic              lk_rsp_valid,
   input logic              hit_valid,
   input logic [1:0]        hit_kind,
   input logic              itt_wr_valid
);
   // table the next lookup must target, tracked from handshakes only
   logic [1:0] nxt_tbl;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nxt_tbl <= 2'd0;
      else if (req_valid && req_ready) nxt_tbl <= 2'd0;
      else if (lk_req_valid && lk_req_ready) nxt_tbl <= lk_req_tbl + 2'd1;
   end

   p_idle_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && lk_req_valid));

   p_disabled_regwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_kind == 2'd0 && !ctl_enable) |=> (req_ready && !lk_req_valid));

   p_stage_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req_valid |-> (lk_req_tbl == nxt_tbl));

   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req_valid && !lk_req_ready) |=> (lk_req_valid && $stable(lk_req_tbl) && $stable(lk_req_addr)));

   p_hit_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |=> !hit_valid);

   p_hit_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid || itt_wr_valid) |-> $past(lk_rsp_valid));

   p_no_discard_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> (hit_kind != 2'd2));

   p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      itt_wr_valid |=> !itt_wr_valid);

   p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_valid && itt_wr_valid));
endmodule

bind itl_lookup_engine itl_lookup_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/itl_lookup_engine_tb_top.sv
module itl_lookup_engine_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        rst_n, ctl_enable, req_valid, req_ready, wr_half;
   logic [1:0]  req_kind;
   logic [63:0] cmd_dw0, cmd_dw1;
   logic [31:0] wr_data;
   logic [19:0] wr_reqid;
   logic        lk_req_valid, lk_req_ready, lk_rsp_valid;
   logic [1:0]  lk_req_tbl;
   logic [47:0] lk_req_addr;
   logic [63:0] lk_rsp_data;
   logic        hit_valid, itt_wr_valid;
   logic [1:0]  hit_kind;
   logic [23:0] hit_intid;
   logic [15:0] hit_icid;
   logic [47:0] itt_wr_addr;
   logic [63:0] itt_wr_data;

   itl_lookup_engine dut_i (.*);

   int n_checks = 0;
   int n_fail   = 0;
   string cur_req = "";

   logic [63:0] dev_tab [longint];
   logic [63:0] xl_tab  [longint];
   logic [63:0] col_tab [longint];
   logic [49:0] exp_lk  [$];
   logic [41:0] exp_hit [$];
   logic [47:0] exp_wr  [$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] rd(input logic [1:0] tbl, input longint a);
      if (tbl == 2'd0) return dev_tab.exists(a) ? dev_tab[a] : 64'h0;
      if (tbl == 2'd1) return xl_tab.exists(a) ? xl_tab[a] : 64'h0;
      return col_tab.exists(a) ? col_tab[a] : 64'h0;
   endfunction

   // behavioural reference: list of lookups and outcome
   task automatic predict(input logic [1:0] kind, input longint devid, input longint ev, input bit en);
      logic [63:0] d, t, c;
      longint lim, xa;
      if (kind == 2'd0 && !en) return;
      if (devid > 4095) return;
      exp_lk.push_back({2'd0, 48'(devid)});
      d = rd(2'd0, devid);
      if (!d[0]) return;
      lim = 64'd1 << (d[5:1] + 1);
      if (ev > lim) return;
      xa = ((longint'(d[45:6])) << 8) + ev * 8;
      xa = xa & 64'hFFFF_FFFF_FFFF;
      exp_lk.push_back({2'd1, 48'(xa)});
      t = rd(2'd1, xa);
      if (!(t[0] && t[1])) return;
      exp_lk.push_back({2'd2, 32'd0, t[47:32]});
      c = rd(2'd2, longint'(t[47:32]));
      if (!c[0]) return;
      if (kind == 2'd2) exp_wr.push_back(48'(xa));
      else exp_hit.push_back({kind, t[31:8], t[47:32]});
   endtask

   // lookup responder: one stall cycle, response two cycles after taking
   initial begin
      automatic int rsp_cnt = 0;
      automatic bit stalled = 0;
      automatic logic [1:0] p_tbl = 0;
      automatic longint p_addr = 0;
      lk_req_ready = 0; lk_rsp_valid = 0; lk_rsp_data = 0;
      forever begin
         @(negedge clk);
         lk_rsp_valid = 0;
         lk_req_ready = 0;
         if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
               lk_rsp_valid = 1;
               lk_rsp_data  = rd(p_tbl, p_addr);
            end
         end else if (rst_n && lk_req_valid) begin
            if (!stalled) stalled = 1;
            else begin
               stalled = 0;
               lk_req_ready = 1;
               p_tbl  = lk_req_tbl;
               p_addr = longint'(lk_req_addr);
               if (exp_lk.size() == 0)
                  check(0, cur_req, "R6 unexpected lookup", {p_tbl, lk_req_addr}, 0);
               else begin
                  automatic logic [49:0] e = exp_lk.pop_front();
                  check({p_tbl, lk_req_addr} == e, cur_req, "R6 lookup tbl/addr", {p_tbl, lk_req_addr}, e);
               end
               rsp_cnt = 2;
            end
         end
      end
   end

   // output monitor, every clock
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && hit_valid) begin
            if (exp_hit.size() == 0) check(0, cur_req, "R10 unexpected hit", {hit_kind, hit_intid, hit_icid}, 0);
            else begin
               automatic logic [41:0] e = exp_hit.pop_front();
               check({hit_kind, hit_intid, hit_icid} == e, cur_req, "R10 hit kind/intid/icid",
                     {hit_kind, hit_intid, hit_icid}, e);
            end
         end
         if (rst_n && itt_wr_valid) begin
            if (exp_wr.size() == 0) check(0, cur_req, "R11 unexpected write", itt_wr_addr, 0);
            else begin
               automatic logic [47:0] e = exp_wr.pop_front();
               check(itt_wr_addr == e, cur_req, "R11 write addr", itt_wr_addr, e);
            end
            check(itt_wr_data == 64'h0, cur_req, "R11 write data zero", itt_wr_data, 0);
            xl_tab[longint'(itt_wr_addr)] = itt_wr_data;
         end
      end
   end

   task automatic run(input string tag, input logic [1:0] kind, input logic [63:0] d0, input logic [63:0] d1,
                      input logic [31:0] wd, input bit half, input logic [19:0] rid, input bit en);
      longint devid, ev;
      cur_req = tag;
      if (kind == 2'd0) begin
         devid = longint'(rid);
         ev    = half ? longint'(wd[15:0]) : longint'(wd);
      end else begin
         devid = longint'(d0[51:32]);
         ev    = longint'(d1[31:0]);
      end
      predict(kind, devid, ev, en);
      @(negedge clk);
      req_kind = kind; cmd_dw0 = d0; cmd_dw1 = d1; wr_data = wd; wr_half = half;
      wr_reqid = rid; ctl_enable = en; req_valid = 1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      while (!req_ready) @(negedge clk);
      repeat (3) @(negedge clk);
      check(exp_lk.size() + exp_hit.size() + exp_wr.size() == 0, tag, "R12 pending expectations",
            exp_lk.size() + exp_hit.size() + exp_wr.size(), 0);
      check(req_ready == 1'b1, tag, "R1 ready after request", req_ready, 1);
      exp_lk.delete(); exp_hit.delete(); exp_wr.delete();
   endtask

   function automatic logic [63:0] dw0_of(input int devid);
      return {12'hABC, 20'(devid), 32'hDEAD_BEEF};
   endfunction

   function automatic logic [63:0] dw1_of(input longint ev);
      return {32'hCAFE_F00D, 32'(ev)};
   endfunction

   localparam longint XB = 64'h10000;

   initial begin
      rst_n = 0; ctl_enable = 1; req_valid = 0; req_kind = 0; cmd_dw0 = 0; cmd_dw1 = 0;
      wr_data = 0; wr_half = 0; wr_reqid = 0;
      // device 3: valid, size 3 (range 16), base 0x100
      dev_tab[3]  = (64'h100 << 6) | (64'd3 << 1) | 64'd1;
      xl_tab[XB + 5*8]  = (64'd7 << 32) | (64'h2005 << 8) | 64'd3;
      xl_tab[XB + 16*8] = (64'd7 << 32) | (64'h2010 << 8) | 64'd3;
      xl_tab[XB + 6*8]  = (64'd7 << 32) | (64'h2006 << 8) | 64'd1;
      xl_tab[XB + 8*8]  = (64'd9 << 32) | (64'h2008 << 8) | 64'd3;
      col_tab[7] = 64'h1;
      col_tab[9] = 64'h2;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
      check(hit_valid == 1'b0, "R1", "reset hit_valid", hit_valid, 0);
      check(itt_wr_valid == 1'b0, "R1", "reset itt_wr_valid", itt_wr_valid, 0);
      check(lk_req_valid == 1'b0, "R1", "reset lk_req_valid", lk_req_valid, 0);

      run("R4 R10 INT hit", 2'd3, dw0_of(3), dw1_of(5), 32'h0, 0, 20'h0, 1);
      run("R10 CLEAR hit", 2'd1, dw0_of(3), dw1_of(5), 32'h0, 0, 20'h0, 1);
      run("R2 regwr full", 2'd0, 64'h0, 64'h0, 32'd5, 0, 20'd3, 1);
      run("R2 regwr half", 2'd0, 64'h0, 64'h0, 32'hABCD_0005, 1, 20'd3, 1);
      run("R7 regwr wide event out of range", 2'd0, 64'h0, 64'h0, 32'hABCD_0005, 0, 20'd3, 1);
      run("R3 regwr disabled", 2'd0, 64'h0, 64'h0, 32'd5, 0, 20'd3, 0);
      run("R3 command while disabled", 2'd3, dw0_of(3), dw1_of(16), 32'h0, 0, 20'h0, 0);
      run("R5 devid above limit", 2'd3, dw0_of(4096), dw1_of(5), 32'h0, 0, 20'h0, 1);
      run("R5 devid at limit", 2'd3, dw0_of(4095), dw1_of(5), 32'h0, 0, 20'h0, 1);
      run("R7 invalid device", 2'd3, dw0_of(4), dw1_of(5), 32'h0, 0, 20'h0, 1);
      run("R7 event at range edge", 2'd1, dw0_of(3), dw1_of(16), 32'h0, 0, 20'h0, 1);
      run("R7 event past range edge", 2'd3, dw0_of(3), dw1_of(17), 32'h0, 0, 20'h0, 1);
      run("R8 non-physical entry", 2'd3, dw0_of(3), dw1_of(6), 32'h0, 0, 20'h0, 1);
      run("R8 unmapped entry", 2'd3, dw0_of(3), dw1_of(7), 32'h0, 0, 20'h0, 1);
      run("R9 invalid collection", 2'd3, dw0_of(3), dw1_of(8), 32'h0, 0, 20'h0, 1);
      run("R12 DISCARD failing", 2'd2, dw0_of(3), dw1_of(8), 32'h0, 0, 20'h0, 1);
      run("R11 DISCARD success", 2'd2, dw0_of(3), dw1_of(5), 32'h0, 0, 20'h0, 1);
      run("R11 INT after DISCARD", 2'd3, dw0_of(3), dw1_of(5), 32'h0, 0, 20'h0, 1);
      run("R10 INT other event", 2'd3, dw0_of(3), dw1_of(16), 32'h0, 0, 20'h0, 1);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule